// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits on the cartridge side of an 8-bit processor bus with a 16-bit address. The processor cannot write to ROM, so the controller treats any write into the lower half of the address space as an update to one of four small control registers. It then uses those registers to widen each processor address into a physical address for a large external ROM and for a banked save RAM. The storage arrays are outside the block. The controller drives their addresses and write strobe, and it chooses which of the two returned bytes goes back onto the processor bus.

Two static inputs describe the cartridge. The ROM size code gives the number of 16 KiB banks as 2 << code, for codes 0 to 6. A code of 7 is treated as 6. The RAM size code selects no RAM (0), 2 KiB (1), 8 KiB (2) or 32 KiB in four 8 KiB pages (3). A mode flag decides what the 2-bit secondary register does. In mode 0 the low 16 KiB window is fixed on bank 0. In mode 1 the secondary register also moves that low window, and it pages the 32 KiB RAM.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write with address bits 15:13 = 000 sets the RAM-enable flag when data bits 3:0 equal 0xA and clears it for any other value.
- R2: A write with address bits 15:13 = 001 loads the primary bank register with data bits 4:0, masked to the low min(code+1,5) bits for ROM size code `code`. A result of zero is stored as 1, so the register is never zero.
- R3: A write with address bits 15:13 = 010 loads the 2-bit secondary register from data bits 1:0.
- R4: A write with address bits 15:13 = 011 sets the mode flag to data bit 0. No other access changes the mode.
- R5: For addresses 0x4000–0x7FFF, rom_addr = {bank, cpu_addr[13:0]}, where bank = (secondary·32 + primary) mod 2^(code+1) and code is clamped to 6.
- R6: For addresses 0x0000–0x3FFF, the bank in rom_addr[20:14] is 0 in mode 0 and (secondary·32) mod 2^(code+1) in mode 1. The low 14 bits equal cpu_addr[13:0].
- R7: In 0xA000–0xBFFF, while RAM is disabled or the RAM size code is 0, reads return 0xFF and writes never assert ram_we.
- R8: While RAM is live, ram_addr is cpu_addr[10:0] for code 1 and cpu_addr[12:0] for code 2. For code 3 it is {secondary, cpu_addr[12:0]} in mode 1 and {00, cpu_addr[12:0]} in mode 0. ram_we follows cpu_we.
- R9: After reset, RAM is disabled, the primary register is 1, the secondary register is 0 and the mode is 0.
- R10: cpu_rdata returns rom_rdata for 0x0000–0x7FFF, ram_rdata for a live RAM access, and 0xFF elsewhere. Accesses outside 0xA000–0xBFFF never assert ram_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes take effect on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_we | input | 1 | Processor write strobe |
| rom_size_code | input | 3 | ROM bank count as 2 << code |
| ram_size_code | input | 2 | 0 none, 1 2 KiB, 2 8 KiB, 3 32 KiB |
| cpu_rdata | output | 8 | Read data returned to the processor |
| rom_addr | output | 21 | Physical ROM byte address |
| rom_rdata | input | 8 | Byte from the ROM array |
| ram_addr | output | 15 | Physical RAM byte address |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | Data to the RAM array |
| ram_rdata | input | 8 | Byte from the RAM array |

## Verification
Some properties hold on every cycle, and the assertions check these. The primary register is never zero. Each write loads the enable, secondary and mode registers correctly, and mode changes only on its own write. The low window stays on bank 0 in mode 0, and the in-bank offset passes through unchanged. A closed RAM window reads 0xFF and never strobes a write. The remaining behaviour depends on the size codes and needs the bench scenarios to show it. These cover bank masking for each ROM size, folding the secondary bits into the bank number for large ROMs, the zero-to-one substitution after masking, RAM offset wrap and paging for each RAM size, and the reset state. The bench compares each of these against its own model over every pair of size codes.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  localparam int CPU_AW    = 16;
  localparam int CPU_DW    = 8;
  localparam int PRIM_W    = 5;
  localparam int SEC_W     = 2;
  localparam int BANK_W    = PRIM_W + SEC_W;
  localparam int OFS_W     = 14;
  localparam int ROM_AW    = BANK_W + OFS_W;
  localparam int PAGE_W    = 13;
  localparam int RAM_AW    = PAGE_W + SEC_W;
  localparam int SMALL_W   = 11;
  localparam int ROMCODE_W = 3;
  localparam int RAMCODE_W = 2;

  typedef enum logic [2:0] {
    WIN_ENABLE, WIN_PRIMARY, WIN_SECOND, WIN_MODE, WIN_RAM, WIN_NONE
  } win_e;

  function automatic win_e decode_win(input logic [CPU_AW-1:0] a);
    case (a[15:13])
      3'd0:    return WIN_ENABLE;
      3'd1:    return WIN_PRIMARY;
      3'd2:    return WIN_SECOND;
      3'd3:    return WIN_MODE;
      3'd5:    return WIN_RAM;
      default: return WIN_NONE;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] bank_mask(input logic [ROMCODE_W-1:0] code);
    logic [ROMCODE_W-1:0] c;
    logic [BANK_W:0]      full;
    c    = (code == 3'd7) ? 3'd6 : code;
    full = ((BANK_W+1)'(1) << (c + 3'd1)) - (BANK_W+1)'(1);
    return full[BANK_W-1:0];
  endfunction

  function automatic logic [PRIM_W-1:0] fold_primary(input logic [CPU_DW-1:0] d,
                                                      input logic [ROMCODE_W-1:0] code);
    logic [BANK_W-1:0] m;
    logic [PRIM_W-1:0] v;
    m = bank_mask(code);
    v = d[PRIM_W-1:0] & m[PRIM_W-1:0];
    return (v == '0) ? PRIM_W'(1) : v;
  endfunction

  function automatic logic [BANK_W-1:0] upper_bank(input logic [PRIM_W-1:0] prim,
                                                    input logic [SEC_W-1:0] sec,
                                                    input logic [ROMCODE_W-1:0] code);
    return {sec, prim} & bank_mask(code);
  endfunction

  function automatic logic [BANK_W-1:0] lower_bank(input logic [SEC_W-1:0] sec,
                                                    input logic mode,
                                                    input logic [ROMCODE_W-1:0] code);
    return mode ? ({sec, {PRIM_W{1'b0}}} & bank_mask(code)) : '0;
  endfunction

  function automatic logic [RAM_AW-1:0] ram_offset(input logic [CPU_AW-1:0] a,
                                                    input logic [SEC_W-1:0] sec,
                                                    input logic mode,
                                                    input logic [RAMCODE_W-1:0] code);
    case (code)
      2'd1:    return {{(RAM_AW-SMALL_W){1'b0}}, a[SMALL_W-1:0]};
      2'd2:    return {{SEC_W{1'b0}}, a[PAGE_W-1:0]};
      2'd3:    return {(mode ? sec : {SEC_W{1'b0}}), a[PAGE_W-1:0]};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cbc_regs.sv
module cbc_regs
  import cbc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  win_e                 win,
  input  logic [CPU_DW-1:0]    wdata,
  input  logic [ROMCODE_W-1:0] rom_code,
  output logic                 ram_on,
  output logic [PRIM_W-1:0]    prim,
  output logic [SEC_W-1:0]     sec,
  output logic                 mode
);
  logic hit_enable, hit_primary, hit_second, hit_mode;
  assign hit_enable  = wr && (win == WIN_ENABLE);
  assign hit_primary = wr && (win == WIN_PRIMARY);
  assign hit_second  = wr && (win == WIN_SECOND);
  assign hit_mode    = wr && (win == WIN_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_on <= 1'b0;
      prim   <= PRIM_W'(1);
      sec    <= '0;
      mode   <= 1'b0;
    end else begin
      if (hit_enable)  ram_on <= (wdata[3:0] == 4'hA);
      if (hit_primary) prim   <= fold_primary(wdata, rom_code);
      if (hit_second)  sec    <= wdata[SEC_W-1:0];
      if (hit_mode)    mode   <= wdata[0];
    end
  end

  p_enable_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit_enable |=> (ram_on == ($past(wdata[3:0]) == 4'hA)));
  p_primary_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prim != '0);
  p_second_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_second |=> (sec == $past(wdata[SEC_W-1:0])));
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mode |=> $stable(mode));
endmodule

// File: rtl/cbc_map.sv
module cbc_map
  import cbc_pkg::*;
(
  input  logic [CPU_AW-1:0]    addr,
  input  logic [PRIM_W-1:0]    prim,
  input  logic [SEC_W-1:0]     sec,
  input  logic                 mode,
  input  logic [ROMCODE_W-1:0] rom_code,
  input  logic [RAMCODE_W-1:0] ram_code,
  output logic [ROM_AW-1:0]    rom_addr,
  output logic [RAM_AW-1:0]    ram_addr
);
  logic [BANK_W-1:0] bank;
  always_comb begin
    if (addr[14]) bank = upper_bank(prim, sec, rom_code);
    else          bank = lower_bank(sec, mode, rom_code);
  end
  assign rom_addr = {bank, addr[OFS_W-1:0]};
  assign ram_addr = ram_offset(addr, sec, mode, ram_code);
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cbc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_wdata,
  input  logic                 cpu_we,
  input  logic [2:0]           rom_size_code,
  input  logic [1:0]           ram_size_code,
  output logic [7:0]           cpu_rdata,
  output logic [20:0]          rom_addr,
  input  logic [7:0]           rom_rdata,
  output logic [14:0]          ram_addr,
  output logic                 ram_we,
  output logic [7:0]           ram_wdata,
  input  logic [7:0]           ram_rdata
);
  win_e              win;
  logic              ram_on, mode, in_rom, in_ram, ram_live;
  logic [PRIM_W-1:0] prim;
  logic [SEC_W-1:0]  sec;

  assign win      = decode_win(cpu_addr);
  assign in_rom   = !cpu_addr[15];
  assign in_ram   = (win == WIN_RAM);
  assign ram_live = in_ram && ram_on && (ram_size_code != '0);

  cbc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(cpu_we), .win(win), .wdata(cpu_wdata),
    .rom_code(rom_size_code), .ram_on(ram_on), .prim(prim), .sec(sec), .mode(mode)
  );

  cbc_map u_map (
    .addr(cpu_addr), .prim(prim), .sec(sec), .mode(mode),
    .rom_code(rom_size_code), .ram_code(ram_size_code),
    .rom_addr(rom_addr), .ram_addr(ram_addr)
  );

  assign ram_we    = cpu_we && ram_live;
  assign ram_wdata = cpu_wdata;

  always_comb begin
    if (in_rom)        cpu_rdata = rom_rdata;
    else if (ram_live) cpu_rdata = ram_rdata;
    else               cpu_rdata = 8'hFF;
  end

  p_low_bank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b00 && !mode) |-> (rom_addr[20:14] == '0));
  p_offset_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b01) |-> (rom_addr[13:0] == cpu_addr[13:0]));
  p_closed_ram_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ram && !ram_on) |-> (cpu_rdata == 8'hFF && !ram_we));
  p_no_stray_we_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ram |-> !ram_we);
endmodule

// File: tb/sim_cart_bank_ctrl.sv
module sim_cart_bank_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_we = 1'b0;
  logic [2:0]  rom_size_code = '0;
  logic [1:0]  ram_size_code = '0;
  logic [7:0]  cpu_rdata, rom_rdata, ram_wdata, ram_rdata;
  logic [20:0] rom_addr;
  logic [14:0] ram_addr;
  logic        ram_we;

  int nvec = 0, nfail = 0;
  bit done = 0;

  // model state
  bit m_on; int m_prim, m_sec, m_mode;

  always #(CLK_P/2) clk = ~clk;

  assign rom_rdata = rom_addr[7:0] ^ {1'b0, rom_addr[20:14]};
  assign ram_rdata = ram_addr[7:0] ^ {1'b0, ram_addr[14:8]};

  cart_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .rom_size_code(rom_size_code), .ram_size_code(ram_size_code),
    .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic int span();
    int c = (rom_size_code == 3'd7) ? 6 : int'(rom_size_code);
    return 1 << (c + 1);
  endfunction

  function automatic int exp_rom(input int a);
    int bank;
    if (a >= 'h4000) bank = (m_sec * 32 + m_prim) % span();
    else             bank = m_mode ? (m_sec * 32) % span() : 0;
    return bank * 'h4000 + (a % 'h4000);
  endfunction

  function automatic int exp_ram(input int a);
    int o = a - 'hA000;
    case (ram_size_code)
      2'd1: return o % 2048;
      2'd2: return o % 8192;
      2'd3: return (m_mode ? m_sec : 0) * 8192 + o;
      default: return 0;
    endcase
  endfunction

  function automatic int stub(input int x);
    return (x % 256) ^ (x / 16384 % 128 % 256);
  endfunction

  function automatic int stub_ram(input int x);
    return (x % 256) ^ (x / 256);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_write(input int a, input int d);
    int nb, lim, v;
    if (a < 'h2000) m_on = ((d % 16) == 'hA);
    else if (a < 'h4000) begin
      nb = (span() >= 32) ? 32 : span();
      v = (d % 32) % nb;
      m_prim = (v == 0) ? 1 : v;
    end else if (a < 'h6000) m_sec = d % 4;
    else if (a < 'h8000) m_mode = d % 2;
    lim = 0;
  endtask

  task automatic access(input int a, input int d, input bit w);
    bit live;
    int er;
    string t;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = 8'(d); cpu_we = w;
    #1;
    live = m_on && (ram_size_code != 0);
    if (a < 'h8000) begin
      t = (a >= 'h4000) ? "R5" : "R6";
      er = exp_rom(a);
      check(int'(rom_addr) == er, t, int'(rom_addr), er);
      check(int'(cpu_rdata) == stub(er), "R10", int'(cpu_rdata), stub(er));
      check(!ram_we, "R10", int'(ram_we), 0);
    end else if (a >= 'hA000 && a < 'hC000) begin
      if (live) begin
        er = exp_ram(a);
        check(int'(ram_addr) == er, "R8", int'(ram_addr), er);
        if (w) check(ram_we, "R8", int'(ram_we), 1);
        else   check(int'(cpu_rdata) == stub_ram(er), "R8", int'(cpu_rdata), stub_ram(er));
      end else begin
        if (w) check(!ram_we, "R7", int'(ram_we), 0);
        else   check(cpu_rdata == 8'hFF, "R7", int'(cpu_rdata), 'hFF);
      end
    end else begin
      check(!ram_we, "R10", int'(ram_we), 0);
      check(cpu_rdata == 8'hFF, "R10", int'(cpu_rdata), 'hFF);
    end
    @(posedge clk);
    if (w && a < 'h8000) model_write(a, d);
    #1 cpu_we = 1'b0;
  endtask

  task automatic do_reset(input int rc, input int mc);
    @(negedge clk);
    rst_n = 1'b0; cpu_we = 1'b0;
    rom_size_code = 3'(rc); ram_size_code = 2'(mc);
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    m_on = 0; m_prim = 1; m_sec = 0; m_mode = 0;
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state on a 128-bank ROM with 32 KiB RAM
    do_reset(6, 3);
    @(negedge clk); cpu_addr = 16'h4000; #1;
    check(rom_addr == 21'h04000, "R9", int'(rom_addr), 'h4000);
    cpu_addr = 16'hA123; #1;
    check(cpu_rdata == 8'hFF, "R9", int'(cpu_rdata), 'hFF);
    // R1: enable by low nibble, disable by other
    access('h0000, 'h1A, 1);  check(m_on == 1, "R1", int'(m_on), 1);
    access('hA010, 'h00, 0);
    access('h1FFF, 'hAB, 1);
    access('hA010, 'h00, 0);
    // R2: zero and masked-to-zero become 1
    access('h2000, 'h00, 1);  access('h4000, 0, 0);
    access('h3FFF, 'h20, 1);  access('h7FFF, 0, 0);
    // R3/R4/R6: secondary in mode 1 moves the low window
    access('h4000, 'h03, 1);  access('h6000, 'h01, 1);  access('h0000, 0, 0);
    access('h0000, 'h0A, 1);  access('hB000, 'h55, 1);  access('hBFFF, 0, 0);
    access('h6000, 'h00, 1);  access('h1234, 0, 0);     access('hA001, 0, 0);
    // R10: high area
    access('hC000, 'h11, 1);  access('hFFFF, 0, 0);
    // randomized sweep over every size pair
    for (int rc = 0; rc < 8; rc++) begin
      for (int mc = 0; mc < 4; mc++) begin
        do_reset(rc, mc);
        access('h4000, 0, 0);   // R9 per config
        for (int i = 0; i < 250; i++) begin
          int sel = int'($urandom % 10);
          int d = int'($urandom % 256);
          int a;
          case (sel)
            0: begin a = int'($urandom % 'h2000); if ($urandom % 2 == 0) d = (d & 'hF0) | 'hA; end
            1: a = 'h2000 + int'($urandom % 'h2000);
            2: a = 'h4000 + int'($urandom % 'h2000);
            3: a = 'h6000 + int'($urandom % 'h2000);
            4, 5: a = int'($urandom % 'h8000);
            6, 7, 8: a = 'hA000 + int'($urandom % 'h2000);
            default: a = 'h8000 + int'($urandom % 'h8000);
          endcase
          access(a, d, (sel < 4) || ((sel >= 6) && ($urandom % 2 == 1)) || (sel == 9));
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule